// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block holds eight 80-bit registers that two execution domains share. The packed-integer domain names a register by its absolute index and sees only the low 64 bits. The floating-point domain names a register by an offset from a stack-top pointer. The physical register it reaches is `(stk_top + offset) mod 8`. Both domains read and write the same flops, so a value written through one view can be read through the other.

A packed write stores its 64-bit operand in the low field. In the same edge it loads all ones into bits 79:64. A floating-point read of that register therefore sees an all-ones exponent and sign, which reads as a NaN or infinity. Any packed access moves the block into packed mode. It also clears the stack-top pointer and marks every register valid. A separate exit strobe marks every register empty and returns the block to stack mode.

The mode controller is a two-state machine:

- `VIEW_STACK` is the reset state. It moves to `VIEW_PACKED` on any packed access without the exit strobe.
- `VIEW_PACKED` returns to `VIEW_STACK` when `pk_exit` is high.

`N_ENT` must be a power of two so that the offset addition wraps naturally.

Top module: `alias_regfile`

## Requirements
- R1: After reset every register reads as zero, `tag_valid` is 0, `stk_top` is 0 and `view_packed` is 0 (state `VIEW_STACK`).
- R2: A packed write with `pk_wr_en`=1 stores `pk_wr_data` in bits 63:0 of register `pk_wr_idx` and sets bits 79:64 to all ones at the next rising edge.
- R3: `pk_rd0_data` and `pk_rd1_data` combinationally return bits 63:0 of the registers at `pk_rd0_idx` and `pk_rd1_idx`. The two ports are independent, and any pair of indices may be used.
- R4: A read of a register in the same cycle as a write to it returns the old contents; the new value appears from the following cycle.
- R5: For floating-point access the physical index is `(stk_top + offset) mod 8`, using the current `stk_top`. `fp_rd_data` returns all 80 bits combinationally. An `fp_wr_en` write stores all 80 bits, and the new low 64 bits are visible to packed reads.
- R6: With no packed access, `fp_push` alone decrements `stk_top` mod 8 and `fp_pop` alone increments it mod 8. Both together, or neither, leave it unchanged.
- R7: Any packed access (`pk_rd0_en`, `pk_rd1_en` or `pk_wr_en` high) sets `stk_top` to 0 at the next edge, overriding push and pop. Unless `pk_exit` is also high, the same access sets `tag_valid` to all ones and moves the block to `VIEW_PACKED`.
- R8: `pk_exit` clears all bits of `tag_valid` and moves the block to `VIEW_STACK` at the next edge, taking priority over a packed access in the same cycle.
- R9: Outside the cases of R7 and R8, an `fp_wr_en` write sets the valid bit of its target register. A pop without a push clears the valid bit of the register at the current `stk_top`, and the clear wins when both apply to that register.
- R10: When a packed write and a floating-point write target the same physical register in one cycle, the packed write is stored.
- R11: `view_packed` rises only in the cycle after a packed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pk_rd0_en | input | 1 | Packed read port 0 access |
| pk_rd0_idx | input | 3 | Packed read port 0 register index |
| pk_rd0_data | output | 64 | Packed read port 0 data |
| pk_rd1_en | input | 1 | Packed read port 1 access |
| pk_rd1_idx | input | 3 | Packed read port 1 register index |
| pk_rd1_data | output | 64 | Packed read port 1 data |
| pk_wr_en | input | 1 | Packed write enable |
| pk_wr_idx | input | 3 | Packed write register index |
| pk_wr_data | input | 64 | Packed write data |
| fp_rd_off | input | 3 | Stack-relative read offset |
| fp_rd_data | output | 80 | Stack-relative read data |
| fp_wr_en | input | 1 | Stack-relative write enable |
| fp_wr_off | input | 3 | Stack-relative write offset |
| fp_wr_data | input | 80 | Stack-relative write data |
| fp_push | input | 1 | Decrement stack top |
| fp_pop | input | 1 | Increment stack top and release the top register |
| pk_exit | input | 1 | Leave packed mode and mark all registers empty |
| stk_top | output | 3 | Current stack-top pointer |
| tag_valid | output | 8 | Per-register valid bits |
| view_packed | output | 1 | 1 when the controller is in `VIEW_PACKED` |

## Verification
The three read ports are combinational. Their data is due in the same cycle the index is applied, and reflects register contents from before that cycle's edge. Writes, `stk_top`, `tag_valid` and the mode are registered, so they are due one rising edge after the stimulus. The bench drives each stimulus at a falling edge and compares the read ports one time unit later against its model's pre-edge state. It then updates its model at the rising edge and compares the registered outputs at the next falling edge, so every comparison lands in the cycle its result is due. The sweeps cover every index pair on the packed ports and every offset at every stack-top value.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

    typedef enum logic {
        VIEW_STACK  = 1'b0,
        VIEW_PACKED = 1'b1
    } view_e;

endpackage

// File: rtl/alias_rf_store.sv
// Storage array: one 80-bit flop register per entry, two write ports.
module alias_rf_store #(
    parameter int N_ENT  = 8,
    parameter int LOW_W  = 64,
    parameter int HIGH_W = 16,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int ENT_W = LOW_W + HIGH_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pk_we,
    input  logic [IDX_W-1:0]            pk_widx,
    input  logic [LOW_W-1:0]            pk_wdata,
    input  logic                        fp_we,
    input  logic [IDX_W-1:0]            fp_widx,
    input  logic [ENT_W-1:0]            fp_wdata,
    output logic [N_ENT-1:0][ENT_W-1:0] ent_q
);

    localparam logic [HIGH_W-1:0] HIGH_FILL = {HIGH_W{1'b1}};

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [ENT_W-1:0] q;
        logic             pk_hit;
        logic             fp_hit;

        assign pk_hit = pk_we && (pk_widx == IDX_W'(e));
        assign fp_hit = fp_we && (fp_widx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (pk_hit) begin
                // packed store wins over a stack store to the same entry
                q <= {HIGH_FILL, pk_wdata};
            end else if (fp_hit) begin
                q <= fp_wdata;
            end
        end

        assign ent_q[e] = q;
    end

endmodule

// File: rtl/alias_rf_rdport.sv
// Combinational read selector; OUT_W picks how many low bits are returned.
module alias_rf_rdport #(
    parameter int N_ENT  = 8,
    parameter int ENT_W  = 80,
    parameter int OUT_W  = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0][ENT_W-1:0] ent,
    input  logic [IDX_W-1:0]            idx,
    output logic [OUT_W-1:0]            data
);

    logic [ENT_W-1:0] sel;

    always_comb begin
        sel  = ent[idx];
        data = sel[OUT_W-1:0];
    end

endmodule

// File: rtl/alias_rf_ctrl.sv
// Mode state machine, stack-top pointer and valid bits.
module alias_rf_ctrl
    import alias_rf_pkg::*;
#(
    parameter int N_ENT  = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pk_any,
    input  logic             pk_exit,
    input  logic             fp_push,
    input  logic             fp_pop,
    input  logic             fp_we,
    input  logic [IDX_W-1:0] fp_widx,
    output logic [IDX_W-1:0] top_q,
    output logic [N_ENT-1:0] valid_q,
    output logic             view_packed
);

    view_e            state_q;
    view_e            state_d;
    logic [IDX_W-1:0] top_d;
    logic [N_ENT-1:0] valid_d;
    logic             push_only;
    logic             pop_only;

    assign push_only = fp_push && !fp_pop;
    assign pop_only  = fp_pop && !fp_push;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VIEW_STACK;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIEW_STACK: begin
                if (pk_any && !pk_exit) begin
                    state_d = VIEW_PACKED;
                end
            end
            VIEW_PACKED: begin
                if (pk_exit) begin
                    state_d = VIEW_STACK;
                end
            end
        endcase
    end

    // outputs of the state machine
    always_comb begin
        view_packed = 1'b0;
        unique case (state_q)
            VIEW_STACK:  view_packed = 1'b0;
            VIEW_PACKED: view_packed = 1'b1;
        endcase
    end

    // stack-top pointer
    always_comb begin
        top_d = top_q;
        if (pk_any) begin
            top_d = '0;
        end else if (push_only) begin
            top_d = top_q - IDX_W'(1);
        end else if (pop_only) begin
            top_d = top_q + IDX_W'(1);
        end
    end

    // valid bits: exit beats packed access beats stack updates
    always_comb begin
        valid_d = valid_q;
        if (fp_we) begin
            valid_d[fp_widx] = 1'b1;
        end
        if (pop_only) begin
            valid_d[top_q] = 1'b0;
        end
        if (pk_any) begin
            valid_d = '1;
        end
        if (pk_exit) begin
            valid_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q   <= '0;
            valid_q <= '0;
        end else begin
            top_q   <= top_d;
            valid_q <= valid_d;
        end
    end

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
    parameter int N_ENT  = 8,
    parameter int LOW_W  = 64,
    parameter int HIGH_W = 16,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int ENT_W = LOW_W + HIGH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pk_rd0_en,
    input  logic [IDX_W-1:0] pk_rd0_idx,
    output logic [LOW_W-1:0] pk_rd0_data,
    input  logic             pk_rd1_en,
    input  logic [IDX_W-1:0] pk_rd1_idx,
    output logic [LOW_W-1:0] pk_rd1_data,
    input  logic             pk_wr_en,
    input  logic [IDX_W-1:0] pk_wr_idx,
    input  logic [LOW_W-1:0] pk_wr_data,
    input  logic [IDX_W-1:0] fp_rd_off,
    output logic [ENT_W-1:0] fp_rd_data,
    input  logic             fp_wr_en,
    input  logic [IDX_W-1:0] fp_wr_off,
    input  logic [ENT_W-1:0] fp_wr_data,
    input  logic             fp_push,
    input  logic             fp_pop,
    input  logic             pk_exit,
    output logic [IDX_W-1:0] stk_top,
    output logic [N_ENT-1:0] tag_valid,
    output logic             view_packed
);

    logic [N_ENT-1:0][ENT_W-1:0] ent_q;
    logic                        pk_any;
    logic [IDX_W-1:0]            fp_rd_phys;
    logic [IDX_W-1:0]            fp_wr_phys;

    assign pk_any = pk_rd0_en || pk_rd1_en || pk_wr_en;

    // stack-relative to physical: wraps because N_ENT is a power of two
    assign fp_rd_phys = stk_top + fp_rd_off;
    assign fp_wr_phys = stk_top + fp_wr_off;

    alias_rf_ctrl #(.N_ENT(N_ENT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pk_any      (pk_any),
        .pk_exit     (pk_exit),
        .fp_push     (fp_push),
        .fp_pop      (fp_pop),
        .fp_we       (fp_wr_en),
        .fp_widx     (fp_wr_phys),
        .top_q       (stk_top),
        .valid_q     (tag_valid),
        .view_packed (view_packed)
    );

    alias_rf_store #(.N_ENT(N_ENT), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pk_we    (pk_wr_en),
        .pk_widx  (pk_wr_idx),
        .pk_wdata (pk_wr_data),
        .fp_we    (fp_wr_en),
        .fp_widx  (fp_wr_phys),
        .fp_wdata (fp_wr_data),
        .ent_q    (ent_q)
    );

    alias_rf_rdport #(.N_ENT(N_ENT), .ENT_W(ENT_W), .OUT_W(LOW_W)) u_rd_pk0 (
        .ent  (ent_q),
        .idx  (pk_rd0_idx),
        .data (pk_rd0_data)
    );

    alias_rf_rdport #(.N_ENT(N_ENT), .ENT_W(ENT_W), .OUT_W(LOW_W)) u_rd_pk1 (
        .ent  (ent_q),
        .idx  (pk_rd1_idx),
        .data (pk_rd1_data)
    );

    alias_rf_rdport #(.N_ENT(N_ENT), .ENT_W(ENT_W), .OUT_W(ENT_W)) u_rd_fp (
        .ent  (ent_q),
        .idx  (fp_rd_phys),
        .data (fp_rd_data)
    );

endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
    parameter int N_ENT  = 8,
    parameter int LOW_W  = 64,
    parameter int HIGH_W = 16,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int ENT_W = LOW_W + HIGH_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pk_any,
    input logic                        pk_wr_en,
    input logic [IDX_W-1:0]            pk_wr_idx,
    input logic [LOW_W-1:0]            pk_wr_data,
    input logic                        fp_push,
    input logic                        fp_pop,
    input logic                        pk_exit,
    input logic [IDX_W-1:0]            stk_top,
    input logic [N_ENT-1:0]            tag_valid,
    input logic                        view_packed,
    input logic [N_ENT-1:0][ENT_W-1:0] ent_q
);

    logic [IDX_W-1:0] top_dec;
    logic [IDX_W-1:0] top_inc;
    assign top_dec = stk_top - IDX_W'(1);
    assign top_inc = stk_top + IDX_W'(1);

    // R2
    pk_wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_wr_en |=> ent_q[$past(pk_wr_idx)] == {{HIGH_W{1'b1}}, $past(pk_wr_data)});

    // R6
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_push && !fp_pop && !pk_any) |=> stk_top == $past(top_dec));

    // R6
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_pop && !fp_push && !pk_any) |=> stk_top == $past(top_inc));

    // R7
    pk_top_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_any |=> stk_top == '0);

    // R7
    pk_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_any && !pk_exit) |=> (tag_valid == '1) && view_packed);

    // R8
    exit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_exit |=> (tag_valid == '0) && !view_packed);

    // R11
    view_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(view_packed) |-> $past(pk_any));

endmodule

bind alias_regfile alias_regfile_chk #(
    .N_ENT(N_ENT), .LOW_W(LOW_W), .HIGH_W(HIGH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pk_any      (pk_any),
    .pk_wr_en    (pk_wr_en),
    .pk_wr_idx   (pk_wr_idx),
    .pk_wr_data  (pk_wr_data),
    .fp_push     (fp_push),
    .fp_pop      (fp_pop),
    .pk_exit     (pk_exit),
    .stk_top     (stk_top),
    .tag_valid   (tag_valid),
    .view_packed (view_packed),
    .ent_q       (ent_q)
);

// File: tb/alias_regfile_test.sv
module alias_regfile_test;

    localparam int CLK_P = 10;

    logic        clk;
    logic        rst_n;
    logic        pk_rd0_en, pk_rd1_en, pk_wr_en;
    logic [2:0]  pk_rd0_idx, pk_rd1_idx, pk_wr_idx;
    logic [63:0] pk_rd0_data, pk_rd1_data, pk_wr_data;
    logic [2:0]  fp_rd_off, fp_wr_off;
    logic [79:0] fp_rd_data, fp_wr_data;
    logic        fp_wr_en, fp_push, fp_pop, pk_exit;
    logic [2:0]  stk_top;
    logic [7:0]  tag_valid;
    logic        view_packed;

    alias_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .pk_rd0_en(pk_rd0_en), .pk_rd0_idx(pk_rd0_idx), .pk_rd0_data(pk_rd0_data),
        .pk_rd1_en(pk_rd1_en), .pk_rd1_idx(pk_rd1_idx), .pk_rd1_data(pk_rd1_data),
        .pk_wr_en(pk_wr_en), .pk_wr_idx(pk_wr_idx), .pk_wr_data(pk_wr_data),
        .fp_rd_off(fp_rd_off), .fp_rd_data(fp_rd_data),
        .fp_wr_en(fp_wr_en), .fp_wr_off(fp_wr_off), .fp_wr_data(fp_wr_data),
        .fp_push(fp_push), .fp_pop(fp_pop), .pk_exit(pk_exit),
        .stk_top(stk_top), .tag_valid(tag_valid), .view_packed(view_packed)
    );

    // reference model
    logic [79:0] m_ent [8];
    logic [2:0]  m_top;
    logic [7:0]  m_valid;
    logic        m_view;

    int n_chk  = 0;
    int n_fail = 0;

    initial begin
        clk = 1'b0;
        forever #(CLK_P / 2) clk = ~clk;
    end

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pk_rd0_en = 0; pk_rd1_en = 0; pk_wr_en = 0;
        fp_wr_en = 0; fp_push = 0; fp_pop = 0; pk_exit = 0;
    endtask

    task automatic model_step();
        logic       any;
        logic [2:0] wphys;
        logic [2:0] t0;
        any   = pk_rd0_en | pk_rd1_en | pk_wr_en;
        t0    = m_top;
        wphys = t0 + fp_wr_off;
        if (fp_wr_en) m_ent[wphys] = fp_wr_data;
        if (pk_wr_en) m_ent[pk_wr_idx] = {16'hFFFF, pk_wr_data};
        if (fp_wr_en) m_valid[wphys] = 1'b1;
        if (fp_pop && !fp_push) m_valid[t0] = 1'b0;
        if (any) m_valid = 8'hFF;
        if (pk_exit) m_valid = 8'h00;
        if (any) m_top = 3'd0;
        else if (fp_push && !fp_pop) m_top = t0 - 3'd1;
        else if (fp_pop && !fp_push) m_top = t0 + 3'd1;
        if (pk_exit) m_view = 1'b0;
        else if (any) m_view = 1'b1;
    endtask

    // called just after a falling edge with inputs already driven
    task automatic tick(input string tag);
        logic [2:0] rphys;
        #1;
        rphys = m_top + fp_rd_off;
        chk({tag, " rd0"}, {16'h0, pk_rd0_data}, {16'h0, m_ent[pk_rd0_idx][63:0]});
        chk({tag, " rd1"}, {16'h0, pk_rd1_data}, {16'h0, m_ent[pk_rd1_idx][63:0]});
        chk({tag, " fprd"}, fp_rd_data, m_ent[rphys]);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " top"}, {77'h0, stk_top}, {77'h0, m_top});
        chk({tag, " valid"}, {72'h0, tag_valid}, {72'h0, m_valid});
        chk({tag, " view R11"}, {79'h0, view_packed}, {79'h0, m_view});
        idle();
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h1111_0101_2222_0303);
    endfunction

    initial begin
        idle();
        pk_rd0_idx = 0; pk_rd1_idx = 0; pk_wr_idx = 0; pk_wr_data = 0;
        fp_rd_off = 0; fp_wr_off = 0; fp_wr_data = 0;
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) m_ent[i] = '0;
        m_top = 0; m_valid = 0; m_view = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, every register via the stack view
        chk("R1 top", {77'h0, stk_top}, 80'h0);
        chk("R1 valid", {72'h0, tag_valid}, 80'h0);
        chk("R1 view", {79'h0, view_packed}, 80'h0);
        for (int o = 0; o < 8; o++) begin
            fp_rd_off = 3'(o);
            #1;
            chk("R1 entry", fp_rd_data, 80'h0);
        end

        // R2: packed writes to every register, high field filled
        for (int i = 0; i < 8; i++) begin
            pk_wr_en = 1; pk_wr_idx = 3'(i); pk_wr_data = pat(i);
            tick("R2 write");
        end
        for (int i = 0; i < 8; i++) begin
            fp_rd_off = 3'(i);
            #1;
            chk("R2 fill", fp_rd_data, {16'hFFFF, pat(i)});
            @(negedge clk);
        end

        // R3: every index pair on both packed read ports
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                pk_rd0_en = 1; pk_rd1_en = 1;
                pk_rd0_idx = 3'(a); pk_rd1_idx = 3'(b);
                tick("R3 pair");
            end
        end

        // R8: leave packed mode
        pk_exit = 1;
        tick("R8 exit");

        // R6/R5: push through a full wrap, every offset at every top
        for (int t = 0; t < 9; t++) begin
            fp_push = 1;
            tick("R6 push");
            for (int o = 0; o < 8; o++) begin
                fp_rd_off = 3'(o);
                tick("R5 offset");
            end
        end

        // R6: push and pop together leave top unchanged
        fp_push = 1; fp_pop = 1;
        tick("R6 both");

        // R5/R9: stack writes at several offsets, visible to packed reads
        for (int o = 0; o < 8; o += 3) begin
            fp_wr_en = 1; fp_wr_off = 3'(o);
            fp_wr_data = {16'h4000 + 16'(o), pat(o + 20)};
            tick("R9 fpwr");
        end
        for (int i = 0; i < 8; i++) begin
            pk_rd0_idx = 3'(i);
            #1;
            chk("R5 alias", {16'h0, pk_rd0_data}, {16'h0, m_ent[i][63:0]});
            @(negedge clk);
        end

        // R6/R9: pops wrap and release the top register
        for (int t = 0; t < 9; t++) begin
            fp_pop = 1;
            tick("R9 pop");
        end

        // R9: write to offset 0 while popping: clear wins
        fp_wr_en = 1; fp_wr_off = 0; fp_wr_data = 80'h3FFF_8000_0000_0000_0001;
        fp_pop = 1;
        tick("R9 clearwins");

        // R7: packed read with a push pending
        fp_push = 1; pk_rd1_en = 1; pk_rd1_idx = 3'd5;
        tick("R7 override");
        pk_exit = 1;
        tick("R8 exit2");
        fp_push = 1;
        tick("R6 push2");

        // R8: exit beats a packed access in the same cycle
        pk_exit = 1; pk_rd0_en = 1;
        tick("R8 priority");

        // R4: read and write same register in one cycle
        pk_wr_en = 1; pk_wr_idx = 3'd3; pk_wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        pk_rd0_idx = 3'd3;
        tick("R4 oldval");
        chk("R4 newval", {16'h0, pk_rd0_data}, {16'h0, 64'hDEAD_BEEF_0BAD_F00D});

        // R10: packed and stack writes to register 6 (top is 0)
        pk_wr_en = 1; pk_wr_idx = 3'd6; pk_wr_data = 64'h1234_5678_9ABC_DEF0;
        fp_wr_en = 1; fp_wr_off = 3'd6; fp_wr_data = 80'h7777_6666_5555_4444_3333;
        tick("R10 collide");
        fp_rd_off = 3'd6;
        #1;
        chk("R10 stored", fp_rd_data, {16'hFFFF, 64'h1234_5678_9ABC_DEF0});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule